// File: doc/BRIEF.md
# Row-Register Cached DRAM Controller

This block puts one SRAM row register in front of a behavioural DRAM array. A requester first strobes in a row address, then strobes in a column address with a read or write flag. An internal comparator checks the access row against the row that is held in the register. Reads are always served from the row register. When the row is already held, a read returns its data one clock later without touching the array. When it is not held, the block copies the entire addressed row into the register, records that row as the cached one, and then returns the data.

Writes are always posted to the array. When the written row is the cached one, the same nibble is also written into the row register, so the cached copy stays coherent. A write to any other row leaves the register and its tag unchanged.

A miss holds `busy` high for a fixed, parameterised number of cycles while the row fill runs. While `busy` is high, the block accepts neither access strobes nor row strobes, so the requester keeps its strobe asserted until the fill has finished. A write that arrives during a fill is therefore delayed until the fill is done.

Top module: `rowcache_dram`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low and the cached-row tag is invalid, so the first read is always a miss, even for a row that was cached before the reset.
- R2: When `busy` is low, `row_stb` latches `row_addr`. An access uses the latched row, or `row_addr` itself when `row_stb` is high in the same cycle as `col_stb`. A `row_stb` that arrives while `busy` is high is ignored.
- R3: A read hit raises `rd_valid` and `rd_hit` in the cycle after the access is accepted. `rd_data` is the latest value written to that row and column, and `busy` stays low.
- R4: A read miss raises `busy` for exactly FILL_LAT cycles, starting in the cycle after acceptance. In the first cycle after `busy` falls, `rd_valid` is 1, `rd_hit` is 0 and `rd_data` holds the addressed nibble. `rd_valid` stays low while `busy` is high.
- R5: A miss copies the whole row into the register. After the fill, reads of any other column of that row are hits.
- R6: Every write reaches the array. A later miss on that row returns the written value.
- R7: A write to the cached row also updates the row register, so an immediate read of that column hits with the new value.
- R8: A write to a row that is not cached changes neither the row register nor the tag. A following read of the cached row still hits with the old data.
- R9: An access strobe is not accepted while `busy` is high. A write held across a fill takes effect in the first cycle after `busy` drops.
- R10: Writes never raise `rd_valid`.
- R11: `rd_valid` and `busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_stb | input | 1 | Row address strobe |
| row_addr | input | ROW_W | Row address |
| col_stb | input | 1 | Column strobe: starts an access |
| col_addr | input | COL_W | Column address |
| wr_en | input | 1 | Access is a write when high, a read when low |
| wr_data | input | DQ_W | Write data |
| busy | output | 1 | Row fill in progress; strobes are not accepted |
| rd_valid | output | 1 | Read data valid, one-cycle pulse |
| rd_hit | output | 1 | The valid read was served without a fill |
| rd_data | output | DQ_W | Read data |

## Verification
The bench builds the block with ROW_W=4, COL_W=3, DQ_W=4 and FILL_LAT=3, instead of the default 2048-row by 512-column geometry. With only 16 rows, eight columns and a three-cycle fill, the bench can use the first and last columns of a row, switch between several rows in a few steps, and count every busy cycle of a fill. It can also hold a write across a fill and reset while a row is cached, all within a short run.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;
    localparam int DEF_ROW_W    = 11;
    localparam int DEF_COL_W    = 9;
    localparam int DEF_DQ_W     = 4;
    localparam int DEF_FILL_LAT = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_st_e;

    typedef struct packed {
        logic valid;
        logic hit;
    } rd_resp_t;

    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/rcd_array.sv
`timescale 1ns/1ps
module rcd_array #(
    parameter int ROW_W = 11,
    parameter int COL_W = 9,
    parameter int DQ_W  = 4
) (
    input  logic                          clk,
    input  logic                          wr,
    input  logic [ROW_W-1:0]              wr_row,
    input  logic [COL_W-1:0]              wr_col,
    input  logic [DQ_W-1:0]               wr_data,
    input  logic [ROW_W-1:0]              rd_row,
    output logic [(1<<COL_W)*DQ_W-1:0]    rd_line
);
    localparam int ROW_N  = 1 << ROW_W;
    localparam int LINE_W = (1 << COL_W) * DQ_W;

    // One entry per row; a fill moves a full line in one transfer.
    logic [LINE_W-1:0] mem [ROW_N];

    always_ff @(posedge clk) begin
        if (wr) mem[wr_row][int'(wr_col)*DQ_W +: DQ_W] <= wr_data;
    end

    assign rd_line = mem[rd_row];
endmodule

// File: rtl/rcd_rowreg.sv
`timescale 1ns/1ps
module rcd_rowreg #(
    parameter int COL_W = 9,
    parameter int DQ_W  = 4
) (
    input  logic                          clk,
    input  logic                          fill,
    input  logic [(1<<COL_W)*DQ_W-1:0]    fill_line,
    input  logic                          wr,
    input  logic [COL_W-1:0]              wr_col,
    input  logic [DQ_W-1:0]               wr_data,
    input  logic [COL_W-1:0]              rd_col,
    output logic [DQ_W-1:0]               rd_word
);
    localparam int LINE_W = (1 << COL_W) * DQ_W;

    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (fill)    line_q <= fill_line;
        else if (wr) line_q[int'(wr_col)*DQ_W +: DQ_W] <= wr_data;
    end

    assign rd_word = line_q[int'(rd_col)*DQ_W +: DQ_W];
endmodule

// File: rtl/rcd_tag.sv
`timescale 1ns/1ps
module rcd_tag #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit
);
    logic [ROW_W-1:0] tag_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            vld_q <= 1'b0;
        end else if (load) begin
            tag_q <= load_row;
            vld_q <= 1'b1;
        end
    end

    assign hit = vld_q && (tag_q == cmp_row);
endmodule

// File: rtl/rcd_ctrl.sv
`timescale 1ns/1ps
module rcd_ctrl
    import rcd_pkg::*;
#(
    parameter int FILL_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_req,
    input  logic acc_wr,
    input  logic acc_hit,
    output logic accept,
    output logic fill_start,
    output logic fill_done,
    output logic busy
);
    localparam int CNT_W = cnt_bits(FILL_LAT);

    fill_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;

    assign accept     = acc_req && (st_q == ST_IDLE);
    assign fill_start = accept && !acc_wr && !acc_hit;
    assign fill_done  = (st_q == ST_FILL) && (cnt_q == '0);
    assign busy       = (st_q == ST_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (fill_start) begin
            st_q  <= ST_FILL;
            cnt_q <= CNT_W'(FILL_LAT - 1);
        end else if (fill_done) begin
            st_q  <= ST_IDLE;
        end else if (st_q == ST_FILL) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rowcache_dram.sv
`timescale 1ns/1ps
module rowcache_dram
    import rcd_pkg::*;
#(
    parameter int ROW_W    = DEF_ROW_W,
    parameter int COL_W    = DEF_COL_W,
    parameter int DQ_W     = DEF_DQ_W,
    parameter int FILL_LAT = DEF_FILL_LAT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_stb,
    input  logic [ROW_W-1:0] row_addr,
    input  logic             col_stb,
    input  logic [COL_W-1:0] col_addr,
    input  logic             wr_en,
    input  logic [DQ_W-1:0]  wr_data,
    output logic             busy,
    output logic             rd_valid,
    output logic             rd_hit,
    output logic [DQ_W-1:0]  rd_data
);
    localparam int LINE_W = (1 << COL_W) * DQ_W;

    logic [ROW_W-1:0]  cur_row_q, eff_row, fill_row_q;
    logic [COL_W-1:0]  fill_col_q;
    logic              acc_hit, accept, fill_start, fill_done;
    logic [LINE_W-1:0] arr_line;
    logic [DQ_W-1:0]   cache_word, fill_word, rd_data_q;
    logic              hit_read;
    rd_resp_t          resp_q;

    // Same-cycle row strobe feeds the access directly.
    assign eff_row  = row_stb ? row_addr : cur_row_q;
    assign hit_read = accept && !wr_en && acc_hit;

    rcd_tag #(.ROW_W(ROW_W)) u_tag (
        .clk(clk), .rst(rst), .load(fill_done), .load_row(fill_row_q),
        .cmp_row(eff_row), .hit(acc_hit)
    );

    rcd_ctrl #(.FILL_LAT(FILL_LAT)) u_ctrl (
        .clk(clk), .rst(rst), .acc_req(col_stb), .acc_wr(wr_en),
        .acc_hit(acc_hit), .accept(accept), .fill_start(fill_start),
        .fill_done(fill_done), .busy(busy)
    );

    rcd_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_array (
        .clk(clk), .wr(accept && wr_en), .wr_row(eff_row), .wr_col(col_addr),
        .wr_data(wr_data), .rd_row(fill_row_q), .rd_line(arr_line)
    );

    rcd_rowreg #(.COL_W(COL_W), .DQ_W(DQ_W)) u_rowreg (
        .clk(clk), .fill(fill_done), .fill_line(arr_line),
        .wr(accept && wr_en && acc_hit), .wr_col(col_addr), .wr_data(wr_data),
        .rd_col(col_addr), .rd_word(cache_word)
    );

    assign fill_word = arr_line[int'(fill_col_q)*DQ_W +: DQ_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row_q  <= '0;
            fill_row_q <= '0;
            fill_col_q <= '0;
            resp_q     <= '0;
            rd_data_q  <= '0;
        end else begin
            if (row_stb && !busy) cur_row_q <= row_addr;
            if (fill_start) begin
                fill_row_q <= eff_row;
                fill_col_q <= col_addr;
            end
            resp_q.valid <= hit_read || fill_done;
            resp_q.hit   <= hit_read;
            if (hit_read)       rd_data_q <= cache_word;
            else if (fill_done) rd_data_q <= fill_word;
        end
    end

    assign rd_valid = resp_q.valid;
    assign rd_hit   = resp_q.hit;
    assign rd_data  = rd_data_q;
endmodule

// File: rtl/rcd_checker.sv
`timescale 1ns/1ps
module rcd_checker #(
    parameter int FILL_LAT = 4
) (
    input logic clk,
    input logic rst,
    input logic col_stb,
    input logic wr_en,
    input logic acc_hit,
    input logic busy,
    input logic rd_valid,
    input logic rd_hit
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !rd_valid));

    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (col_stb && !wr_en && !busy && acc_hit) |=> (rd_valid && rd_hit && !busy));

    a_r4_miss_starts_fill: assert property (@(posedge clk) disable iff (rst)
        (col_stb && !wr_en && !busy && !acc_hit) |=> (busy && !rd_valid));

    a_r4_fill_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == FILL_LAT));

    a_r4_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < FILL_LAT));

    a_r4_fill_serves: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (rd_valid && !rd_hit));

    a_r10_write_silent: assert property (@(posedge clk) disable iff (rst)
        (col_stb && wr_en && !busy) |=> !rd_valid);

    a_r11_valid_not_busy: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && busy));
endmodule

bind rowcache_dram rcd_checker #(.FILL_LAT(FILL_LAT)) u_chk (
    .clk(clk), .rst(rst), .col_stb(col_stb), .wr_en(wr_en),
    .acc_hit(acc_hit), .busy(busy), .rd_valid(rd_valid), .rd_hit(rd_hit)
);

// File: tb/rowcache_dram_tb.sv
`timescale 1ns/1ps
module rowcache_dram_tb;
    localparam int RW = 4, CW = 3, DW = 4, LAT = 3;
    localparam logic [1:0] OP_ROW = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] row;
        logic [2:0] col;
        logic [3:0] dat;
        logic       hit;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{OP_ROW, 4'd3,  3'd0, 4'h0, 1'b0, 4'd2},
        '{OP_WR,  4'd0,  3'd1, 4'hA, 1'b0, 4'd6},
        '{OP_WR,  4'd0,  3'd5, 4'h5, 1'b0, 4'd6},
        '{OP_RD,  4'd0,  3'd1, 4'hA, 1'b0, 4'd1},  // R1 first read misses
        '{OP_RD,  4'd0,  3'd5, 4'h5, 1'b1, 4'd5},  // R5 whole row loaded
        '{OP_WR,  4'd0,  3'd5, 4'hC, 1'b0, 4'd7},
        '{OP_RD,  4'd0,  3'd5, 4'hC, 1'b1, 4'd7},  // R7 write-through
        '{OP_ROW, 4'd7,  3'd0, 4'h0, 1'b0, 4'd2},
        '{OP_WR,  4'd0,  3'd2, 4'h9, 1'b0, 4'd8},
        '{OP_ROW, 4'd3,  3'd0, 4'h0, 1'b0, 4'd2},
        '{OP_RD,  4'd0,  3'd1, 4'hA, 1'b1, 4'd8},  // R8 cache untouched
        '{OP_ROW, 4'd7,  3'd0, 4'h0, 1'b0, 4'd2},
        '{OP_RD,  4'd0,  3'd2, 4'h9, 1'b0, 4'd6},  // R6 array holds write
        '{OP_ROW, 4'd3,  3'd0, 4'h0, 1'b0, 4'd2},
        '{OP_RD,  4'd0,  3'd5, 4'hC, 1'b0, 4'd6},  // R6 hit write posted too
        '{OP_ROW, 4'd11, 3'd0, 4'h0, 1'b0, 4'd2},
        '{OP_WR,  4'd0,  3'd1, 4'h6, 1'b0, 4'd6},
        '{OP_RD,  4'd0,  3'd1, 4'h6, 1'b0, 4'd4},
        '{OP_ROW, 4'd3,  3'd0, 4'h0, 1'b0, 4'd2},
        '{OP_RD,  4'd0,  3'd1, 4'hA, 1'b0, 4'd4},
        '{OP_WR,  4'd0,  3'd7, 4'hF, 1'b0, 4'd7},
        '{OP_WR,  4'd0,  3'd0, 4'h1, 1'b0, 4'd7},
        '{OP_RD,  4'd0,  3'd7, 4'hF, 1'b1, 4'd5},  // R5 last column
        '{OP_RD,  4'd0,  3'd0, 4'h1, 1'b1, 4'd5}   // R5 first column
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          row_stb, col_stb, wr_en;
    logic [RW-1:0] row_addr;
    logic [CW-1:0] col_addr;
    logic [DW-1:0] wr_data;
    logic          busy, rd_valid, rd_hit;
    logic [DW-1:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rowcache_dram #(.ROW_W(RW), .COL_W(CW), .DQ_W(DW), .FILL_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .row_stb(row_stb), .row_addr(row_addr),
        .col_stb(col_stb), .col_addr(col_addr), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_row(input int r);
        row_stb  = 1'b1;
        row_addr = RW'(r);
        @(negedge clk);
        row_stb  = 1'b0;
    endtask

    task automatic t_write(input int c, input int d);
        col_stb = 1'b1; wr_en = 1'b1;
        col_addr = CW'(c); wr_data = DW'(d);
        while (busy) @(negedge clk);
        @(negedge clk);
        col_stb = 1'b0; wr_en = 1'b0;
        chk("R10", "rd_valid after write", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_read(input int c, input int d, input bit hit, input string req);
        col_stb = 1'b1; wr_en = 1'b0; col_addr = CW'(c);
        @(negedge clk);
        col_stb = 1'b0; row_stb = 1'b0;
        if (hit) begin
            chk(req, "hit valid", 32'(rd_valid), 32'd1);
            chk(req, "hit flag",  32'(rd_hit),   32'd1);
            chk(req, "hit data",  32'(rd_data),  32'(d));
            chk(req, "busy on hit", 32'(busy),   32'd0);
        end else begin
            chk(req, "busy after miss", 32'(busy), 32'd1);
            chk(req, "early valid", 32'(rd_valid), 32'd0);
            for (int i = 1; i < LAT; i++) begin
                @(negedge clk);
                chk(req, "busy held", 32'(busy), 32'd1);
            end
            @(negedge clk);
            chk(req, "busy released", 32'(busy),   32'd0);
            chk(req, "fill valid",    32'(rd_valid), 32'd1);
            chk(req, "fill hit flag", 32'(rd_hit),   32'd0);
            chk(req, "fill data",     32'(rd_data),  32'(d));
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; row_stb = 1'b0; col_stb = 1'b0; wr_en = 1'b0;
        row_addr = '0; col_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset",     32'(busy),     32'd0);
        chk("R1", "rd_valid after reset", 32'(rd_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_ROW:  t_row(int'(VEC[i].row));
                OP_WR:   t_write(int'(VEC[i].col), int'(VEC[i].dat));
                default: t_read(int'(VEC[i].col), int'(VEC[i].dat), VEC[i].hit,
                                $sformatf("R%0d", VEC[i].req));
            endcase
        end

        // R9: write held across a fill lands once busy drops
        t_row(7);
        col_stb = 1'b1; wr_en = 1'b0; col_addr = 3'd2;
        @(negedge clk);
        chk("R9", "fill started", 32'(busy), 32'd1);
        wr_en = 1'b1; col_addr = 3'd4; wr_data = 4'hD;
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            chk("R9", "busy while write held", 32'(busy), 32'd1);
        end
        @(negedge clk);
        chk("R9", "fill valid", 32'(rd_valid), 32'd1);
        chk("R9", "fill data",  32'(rd_data),  32'h9);
        @(negedge clk);
        col_stb = 1'b0; wr_en = 1'b0;
        chk("R9", "held write no valid", 32'(rd_valid), 32'd0);
        t_read(4, 'hD, 1'b1, "R9");

        // R2: row strobe during a fill is ignored
        t_row(3);
        col_stb = 1'b1; wr_en = 1'b0; col_addr = 3'd1;
        @(negedge clk);
        col_stb = 1'b0;
        chk("R2", "fill started", 32'(busy), 32'd1);
        row_stb = 1'b1; row_addr = 4'd11;
        @(negedge clk);
        row_stb = 1'b0;
        while (busy) @(negedge clk);
        chk("R2", "fill data", 32'(rd_data), 32'hA);
        t_read(1, 'hA, 1'b1, "R2");

        // R2: row strobe in the same cycle as the column strobe
        row_stb = 1'b1; row_addr = 4'd7;
        t_read(2, 'h9, 1'b0, "R2");
        t_read(4, 'hD, 1'b1, "R2");

        // R1: reset drops the cached row; array content survives
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after re-reset",     32'(busy),     32'd0);
        chk("R1", "rd_valid after re-reset", 32'(rd_valid), 32'd0);
        t_row(7);
        t_read(4, 'hD, 1'b0, "R1");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule